// File: doc/BRIEF.md
# Frequency-Shifted Baseband Cavity Compensation Filter

This block applies a fixed cavity-compensation FIR to complex baseband samples while the RF frequency ramps. The filter's zeros belong to the cavity's fixed centre frequency, not to the moving RF carrier. To keep them in place, the block first rotates each complex sample down by the beat frequency, which is the RF frequency minus the cavity centre. It then runs the sample through a programmable FIR clocked by the beam-synchronous sample clock. Finally it rotates the result back up by the same beat frequency.

Both rotations are driven by one numerically controlled oscillator. The down step uses the conjugate of the oscillator output. The up step uses a copy of the same output, delayed so that it lines up with the filter output. A single FIR tap therefore sees zero net rotation, while a tap at delay k picks up the phase advance the oscillator made over k samples. That phase advance is the frequency shift. The beat frequency is set by a 32-bit tuning word that may change on any cycle. The controller that computes it, such as one following a frequency program, lives outside the block. Coefficients are written one tap at a time.

Top module: `fsf_cavity_filter`

## Requirements
- R1: Latency is four clocks for both I and Q. A sample presented before rising edge n appears on the outputs after edge n+3. With tuning word 0 and only tap 0 set to 16384, the output equals the input for |I|,|Q| ≤ 1023.
- R2: With tuning word 0, output = (Σk c[k]·x[n−k] + 8192) >>> 14, then saturated. Here c[k] is the signed 16-bit coefficient in Q2.14 format (16384 = unity), x[n−k] is the input k samples earlier, and there are 8 taps, numbered 0..7.
- R3: When coef_we is high at a rising edge, coef_data is stored into tap coef_addr. The new value applies to every sample filtered after that edge.
- R4: While rst is high, the outputs read 0, every coefficient is cleared and the oscillator phase returns to zero. After release, with tuning word 0, the rotation is by exactly 0 degrees.
- R5: A tap at delay k receives an extra rotation of e^{+j·2π·k·ftw/2^32}. With ftw = 2^30, tap 1 alone maps (I,Q) to (−Q,I) and tap 2 alone maps (I,Q) to (−I,−Q).
- R6: With only tap 0 set to unity, the output tracks the input within ±3 LSB for any tuning word. This still holds on the cycles around a tuning-word change, because the phase continues without a jump.
- R7: The FIR result saturates symmetrically to ±32767 before the up rotation.
- R8: The oscillator has a 32-bit phase accumulator. Its top 2 bits select the quadrant and the next 8 bits address a 257-entry quarter-wave sine table with amplitude 2047 (12-bit signed). Advancing the phase by a quarter turn maps (cos,sin) to (−sin,cos) exactly.
- R9: Each rotator scales its sums of products by 2^−11, rounds half up and saturates symmetrically to ±32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam-synchronous sample clock |
| rst | input | 1 | Synchronous active-high reset |
| in_i | input | 16 | In-phase input sample, signed |
| in_q | input | 16 | Quadrature input sample, signed |
| ftw | input | 32 | Beat-frequency tuning word, phase step per sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 3 | Tap index to write |
| coef_data | input | 16 | Signed Q2.14 coefficient |
| out_i | output | 16 | In-phase filtered output, signed |
| out_q | output | 16 | Quadrature filtered output, signed |

## Verification
The rotation pair and the filter are exercised together. The key case is a tuning-word change landing on the same cycle that samples are moving through the delay line. The bench switches from a positive to a negative beat frequency in the middle of a constant-input run with unity tap 0, and checks every output against the input with a ±3 LSB tolerance. A phase jump or a misaligned up rotation would show up as an error.

A second case sets a quarter-turn tuning word with a single delayed tap. Here rotation and filtering interact in a way whose result is exact, (−Q,I) or (−I,−Q), so the direction of the net rotation and the alignment of the delayed phase are checked to the LSB.

// File: rtl/fsf_pkg.sv
package fsf_pkg;

   typedef enum logic [1:0] {
      QD0 = 2'd0,
      QD1 = 2'd1,
      QD2 = 2'd2,
      QD3 = 2'd3
   } quad_e;

   // Clamp to +/-(2^(w-1)-1); the most negative code is never produced.
   function automatic longint sat_sym(input longint v, input int w);
      longint lim;
      lim = (longint'(1) <<< (w - 1)) - 1;
      if (v > lim) return lim;
      if (v < -lim) return -lim;
      return v;
   endfunction

endpackage

// File: rtl/fsf_nco.sv
module fsf_nco #(
   parameter int PW = 32,
   parameter int LW = 12,
   parameter int AW = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [PW-1:0]        ftw,
   output logic signed [LW-1:0] cos_o,
   output logic signed [LW-1:0] sin_o
);
   import fsf_pkg::*;

   localparam int QN  = 1 << AW;
   localparam int AMP = (1 << (LW - 1)) - 1;
   localparam logic [PW-1:0] QTR = PW'(1) << (PW - 2);

   if (PW < AW + 2) begin : g_bad_pw
      $error("fsf_nco: phase width too small for table address");
   end
   if (LW < 4) begin : g_bad_lw
      $error("fsf_nco: table width too small");
   end

   logic signed [LW-1:0] tbl [0:QN];
   for (genvar g = 0; g <= QN; g++) begin : g_tbl
      localparam real ANG = 3.14159265358979 * real'(g) / real'(2 * QN);
      localparam int  VAL = $rtoi(real'(AMP) * $sin(ANG) + 0.5);
      assign tbl[g] = LW'(VAL);
   end

   logic [PW-1:0]        ph;
   logic [AW:0]          ia, ib;
   logic signed [LW-1:0] c_n, s_n;

   always_comb begin
      ia = {1'b0, ph[PW-3 -: AW]};
      ib = (AW + 1)'(QN) - ia;
      unique case (quad_e'(ph[PW-1 -: 2]))
         QD0:     begin c_n =  tbl[ib]; s_n =  tbl[ia]; end
         QD1:     begin c_n = -tbl[ia]; s_n =  tbl[ib]; end
         QD2:     begin c_n = -tbl[ib]; s_n = -tbl[ia]; end
         default: begin c_n =  tbl[ia]; s_n = -tbl[ib]; end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph    <= '0;
         cos_o <= LW'(AMP);
         sin_o <= '0;
      end else begin
         ph    <= ph + ftw;
         cos_o <= c_n;
         sin_o <= s_n;
      end
   end

   // R8
   nco_quarter_chk: assert property (@(posedge clk) disable iff (rst)
      (ftw == QTR) |-> ##2 (sin_o == $past(cos_o) && cos_o == -$past(sin_o)));

   // R8
   nco_mag_chk: assert property (@(posedge clk) disable iff (rst)
      (int'(cos_o) * int'(cos_o) + int'(sin_o) * int'(sin_o) <= (AMP + 1) * (AMP + 1)) &&
      (int'(cos_o) * int'(cos_o) + int'(sin_o) * int'(sin_o) >= (AMP - 1) * (AMP - 1)));

endmodule

// File: rtl/fsf_rot.sv
module fsf_rot #(
   parameter int DW   = 16,
   parameter int LW   = 12,
   parameter bit CONJ = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic signed [DW-1:0] xi,
   input  logic signed [DW-1:0] xq,
   input  logic signed [LW-1:0] c,
   input  logic signed [LW-1:0] s,
   output logic signed [DW-1:0] yi,
   output logic signed [DW-1:0] yq
);
   import fsf_pkg::*;

   localparam int PWID = DW + LW + 1;
   localparam int SH   = LW - 1;
   localparam logic signed [PWID-1:0] HALF = PWID'(1) <<< (SH - 1);
   localparam logic signed [DW-1:0]   MOST_NEG = {1'b1, {(DW-1){1'b0}}};

   logic signed [PWID-1:0] pic, pqs, pqc, pis, ai, aq, ri, rq;

   always_comb begin
      pic = PWID'(xi) * PWID'(c);
      pqs = PWID'(xq) * PWID'(s);
      pqc = PWID'(xq) * PWID'(c);
      pis = PWID'(xi) * PWID'(s);
   end

   if (CONJ) begin : g_down
      assign ai = pic + pqs;
      assign aq = pqc - pis;
   end else begin : g_up
      assign ai = pic - pqs;
      assign aq = pqc + pis;
   end

   assign ri = (ai + HALF) >>> SH;
   assign rq = (aq + HALF) >>> SH;

   always_ff @(posedge clk) begin
      if (rst) begin
         yi <= '0;
         yq <= '0;
      end else begin
         yi <= DW'(sat_sym(64'(ri), DW));
         yq <= DW'(sat_sym(64'(rq), DW));
      end
   end

   // R9
   rot_sym_chk: assert property (@(posedge clk) disable iff (rst)
      (yi != MOST_NEG) && (yq != MOST_NEG));

endmodule

// File: rtl/fsf_fir.sv
module fsf_fir #(
   parameter int DW   = 16,
   parameter int CW   = 16,
   parameter int TAPS = 8,
   parameter int AW   = 3,
   parameter int FRAC = 14
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 coef_we,
   input  logic [AW-1:0]        coef_addr,
   input  logic signed [CW-1:0] coef_data,
   input  logic signed [DW-1:0] di,
   input  logic signed [DW-1:0] dq,
   output logic signed [DW-1:0] yi,
   output logic signed [DW-1:0] yq
);
   import fsf_pkg::*;

   localparam int ACW = DW + CW + AW + 1;
   localparam logic signed [ACW-1:0] HALF = ACW'(1) <<< (FRAC - 1);
   localparam logic signed [DW-1:0]  MOST_NEG = {1'b1, {(DW-1){1'b0}}};

   if (TAPS < 2 || (1 << AW) < TAPS) begin : g_bad_taps
      $error("fsf_fir: tap count and address width disagree");
   end
   if (FRAC < 1 || FRAC >= CW) begin : g_bad_frac
      $error("fsf_fir: coefficient fraction out of range");
   end

   logic signed [CW-1:0] coef  [TAPS];
   logic signed [DW-1:0] tap_i [TAPS];
   logic signed [DW-1:0] tap_q [TAPS];

   assign tap_i[0] = di;
   assign tap_q[0] = dq;

   for (genvar k = 1; k < TAPS; k++) begin : g_dl
      always_ff @(posedge clk) begin
         if (rst) begin
            tap_i[k] <= '0;
            tap_q[k] <= '0;
         end else begin
            tap_i[k] <= tap_i[k-1];
            tap_q[k] <= tap_q[k-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < TAPS; k++) coef[k] <= '0;
      end else if (coef_we && (int'(coef_addr) < TAPS)) begin
         coef[coef_addr] <= coef_data;
      end
   end

   logic signed [ACW-1:0] si, sq, ri, rq;
   logic                  all_zero;

   always_comb begin
      si = '0;
      sq = '0;
      all_zero = 1'b1;
      for (int k = 0; k < TAPS; k++) begin
         si = si + ACW'(tap_i[k]) * ACW'(coef[k]);
         sq = sq + ACW'(tap_q[k]) * ACW'(coef[k]);
         if (coef[k] != '0) all_zero = 1'b0;
      end
      ri = (si + HALF) >>> FRAC;
      rq = (sq + HALF) >>> FRAC;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         yi <= '0;
         yq <= '0;
      end else begin
         yi <= DW'(sat_sym(64'(ri), DW));
         yq <= DW'(sat_sym(64'(rq), DW));
      end
   end

   // R7
   fir_sym_chk: assert property (@(posedge clk) disable iff (rst)
      (yi != MOST_NEG) && (yq != MOST_NEG));

   // R2
   fir_zero_chk: assert property (@(posedge clk) disable iff (rst)
      all_zero |=> (yi == '0 && yq == '0));

endmodule

// File: rtl/fsf_cavity_filter.sv
module fsf_cavity_filter #(
   parameter int DW   = 16,
   parameter int CW   = 16,
   parameter int TAPS = 8,
   parameter int PW   = 32,
   parameter int LW   = 12,
   parameter int LAW  = 8
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic signed [DW-1:0]         in_i,
   input  logic signed [DW-1:0]         in_q,
   input  logic [PW-1:0]                ftw,
   input  logic                         coef_we,
   input  logic [$clog2(TAPS)-1:0]      coef_addr,
   input  logic signed [CW-1:0]         coef_data,
   output logic signed [DW-1:0]         out_i,
   output logic signed [DW-1:0]         out_q
);
   localparam int CA    = $clog2(TAPS);
   localparam int FRAC  = CW - 2;
   localparam int ALIGN = 2;
   localparam int ZMAX  = TAPS + 3;
   localparam int ZW    = $clog2(ZMAX + 1);

   logic signed [DW-1:0] x_i, x_q, d_i, d_q, f_i, f_q;
   logic signed [LW-1:0] nc, ns;
   logic signed [LW-1:0] cd [ALIGN+1];
   logic signed [LW-1:0] sd [ALIGN+1];

   always_ff @(posedge clk) begin
      if (rst) begin
         x_i <= '0;
         x_q <= '0;
      end else begin
         x_i <= in_i;
         x_q <= in_q;
      end
   end

   fsf_nco #(.PW(PW), .LW(LW), .AW(LAW)) nco_i (
      .clk(clk), .rst(rst), .ftw(ftw), .cos_o(nc), .sin_o(ns));

   fsf_rot #(.DW(DW), .LW(LW), .CONJ(1'b1)) down_i (
      .clk(clk), .rst(rst), .xi(x_i), .xq(x_q), .c(nc), .s(ns),
      .yi(d_i), .yq(d_q));

   // Phase copy delayed to meet the FIR output.
   assign cd[0] = nc;
   assign sd[0] = ns;
   for (genvar a = 1; a <= ALIGN; a++) begin : g_align
      always_ff @(posedge clk) begin
         if (rst) begin
            cd[a] <= '0;
            sd[a] <= '0;
         end else begin
            cd[a] <= cd[a-1];
            sd[a] <= sd[a-1];
         end
      end
   end

   fsf_fir #(.DW(DW), .CW(CW), .TAPS(TAPS), .AW(CA), .FRAC(FRAC)) fir_i (
      .clk(clk), .rst(rst), .coef_we(coef_we), .coef_addr(coef_addr),
      .coef_data(coef_data), .di(d_i), .dq(d_q), .yi(f_i), .yq(f_q));

   fsf_rot #(.DW(DW), .LW(LW), .CONJ(1'b0)) up_i (
      .clk(clk), .rst(rst), .xi(f_i), .xq(f_q), .c(cd[ALIGN]), .s(sd[ALIGN]),
      .yi(out_i), .yq(out_q));

   // Run length of zero input, used by the idle-output check.
   logic [ZW-1:0] zrun;
   always_ff @(posedge clk) begin
      if (rst) zrun <= '0;
      else if (in_i != '0 || in_q != '0) zrun <= '0;
      else if (zrun != ZW'(ZMAX)) zrun <= zrun + 1'b1;
   end

   // R1
   idle_out_chk: assert property (@(posedge clk) disable iff (rst)
      (zrun == ZW'(ZMAX)) |-> (out_i == '0 && out_q == '0));

endmodule

// File: tb/fsf_cavity_filter_tb_top.sv
`timescale 1ns/1ps
module fsf_cavity_filter_tb_top;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic signed [15:0] in_i = '0, in_q = '0;
   logic [31:0]        ftw = '0;
   logic               coef_we = 1'b0;
   logic [2:0]         coef_addr = '0;
   logic signed [15:0] coef_data = '0;
   logic signed [15:0] out_i, out_q;

   int checks = 0;
   int errors = 0;

   int hi [256];
   int hq [256];
   int bc [8];
   int sc;
   int oi, oq, ei, eq;

   always #5 clk = ~clk;

   fsf_cavity_filter dut_i (
      .clk(clk), .rst(rst), .in_i(in_i), .in_q(in_q), .ftw(ftw),
      .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
      .out_i(out_i), .out_q(out_q));

   task automatic chk(input string tag, input int act, input int exp, input int tol);
      checks++;
      if (act > exp + tol || act < exp - tol) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d (tol %0d)", tag, act, exp, tol);
      end
   endtask

   function automatic int sat16(input longint v);
      if (v > 32767) return 32767;
      if (v < -32767) return -32767;
      return int'(v);
   endfunction

   // Model for tuning word 0 and |x| <= 1023 (rotations are exact there).
   function automatic int model(input bit qsel);
      longint acc = 0;
      for (int k = 0; k < 8; k++) begin
         int idx = (sc - 4 - k) & 255;
         acc += longint'(bc[k]) * longint'(qsel ? hq[idx] : hi[idx]);
      end
      return sat16((acc + 8192) >>> 14);
   endfunction

   task automatic step(input int xi, input int xq);
      @(negedge clk);
      oi = out_i;
      oq = out_q;
      ei = model(1'b0);
      eq = model(1'b1);
      in_i = 16'(xi);
      in_q = 16'(xq);
      hi[sc & 255] = xi;
      hq[sc & 255] = xq;
      sc++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_i = '0;
      in_q = '0;
      ftw = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      sc = 0;
      for (int k = 0; k < 256; k++) begin hi[k] = 0; hq[k] = 0; end
      for (int k = 0; k < 8; k++) bc[k] = 0;
   endtask

   task automatic wcoef(input int addr, input int val);
      @(negedge clk);
      in_i = '0;
      in_q = '0;
      coef_we = 1'b1;
      coef_addr = 3'(addr);
      coef_data = 16'(val);
      bc[addr] = val;
      @(negedge clk);
      coef_we = 1'b0;
   endtask

   task automatic flush();
      for (int n = 0; n < 12; n++) step(0, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R4 out_i in reset", out_i, 0, 0);
      chk("R4 out_q in reset", out_q, 0, 0);
      do_reset();
      // Cleared coefficients: nonzero input still gives zero output.
      for (int n = 0; n < 8; n++) step(900, -700);
      chk("R4 coefficients cleared, out_i", oi, 0, 0);
      chk("R4 coefficients cleared, out_q", oq, 0, 0);
   endtask

   task automatic t_unity();
      do_reset();
      wcoef(0, 16384);
      flush();
      step(700, -250);
      for (int n = 1; n <= 6; n++) begin
         step(0, 0);
         if (n == 3) begin
            chk("R1 no output before latency, I", oi, 0, 0);
         end
         if (n == 4) begin
            chk("R1 R4 impulse after 4 clocks, I", oi, 700, 0);
            chk("R1 R4 impulse after 4 clocks, Q", oq, -250, 0);
         end
         if (n == 5) begin
            chk("R1 single sample only, Q", oq, 0, 0);
         end
      end
   endtask

   task automatic run_seq(input string tag, input int n, input int seed);
      for (int s = 0; s < n; s++) begin
         step(((s * 37 + seed) % 401) - 200, ((s * 53 + seed * 3) % 577) - 288);
         if (s >= 4) begin
            chk({tag, " I"}, oi, ei, 0);
            chk({tag, " Q"}, oq, eq, 0);
         end
      end
   endtask

   task automatic t_fir();
      do_reset();
      wcoef(0, 16384);
      wcoef(1, -8192);
      wcoef(3, 4096);
      wcoef(7, -16384);
      flush();
      run_seq("R2 four-tap response", 24, 11);
      flush();
      wcoef(3, -12288);
      wcoef(5, 6000);
      flush();
      run_seq("R3 rewritten taps", 24, 5);
   endtask

   task automatic t_quarter();
      do_reset();
      ftw = 32'h4000_0000;
      wcoef(1, 16384);
      flush();
      for (int n = 0; n < 12; n++) step(300, 100);
      chk("R5 R8 tap1 quarter turn, I", oi, -100, 0);
      chk("R5 R8 tap1 quarter turn, Q", oq, 300, 0);
      wcoef(1, 0);
      wcoef(2, 16384);
      flush();
      for (int n = 0; n < 12; n++) step(300, 100);
      chk("R5 tap2 half turn, I", oi, -300, 0);
      chk("R5 tap2 half turn, Q", oq, -100, 0);
   endtask

   task automatic t_sat();
      do_reset();
      wcoef(0, 16384);
      wcoef(1, 16384);
      flush();
      for (int n = 0; n < 12; n++) step(30000, -30000);
      chk("R7 R9 positive saturation, I", oi, 32751, 0);
      chk("R7 R9 negative saturation, Q", oq, -32751, 0);
   endtask

   task automatic t_track();
      do_reset();
      wcoef(0, 16384);
      ftw = 32'h0123_4567;
      flush();
      for (int n = 0; n < 40; n++) begin
         if (n == 20) ftw = 32'hF765_4321;
         step(500, -300);
         if (n >= 5) begin
            chk("R6 tracking across beat change, I", oi, 500, 3);
            chk("R6 tracking across beat change, Q", oq, -300, 3);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      t_reset();
      t_unity();
      t_fir();
      t_quarter();
      t_sat();
      t_track();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule